// File: doc/BRIEF.md
# Calendar Clock Peripheral with One-Shot Alarm

This block is a real-time calendar that sits on a simple 32-bit register bus. It counts seconds, minutes, hours, day of week, day of month, month and a two-digit year offset. Each advance is driven by a one-cycle pulse on a once-per-second input. A second bank of the same seven fields holds an alarm time. A control byte selects which of those fields take part in the comparison. When the comparison matches, a sticky pending flag is set and an interrupt line is raised.

The counter is locked out of reset. Software must first write seven fixed byte values, one into each of seven key words and in a fixed order. Software must also clear a stop bit before any second is counted. The live time can only be loaded while counting is stopped. The alarm is one-shot: when it fires, the hardware clears its own control byte. It does not re-arm until software writes that byte again.

Top module: `cal_rtc`

## Requirements
- R1: After reset both banks read year 0, month 1, day 1, weekday 0, 00:00:00. The stop bit reads 1, pending reads 0, alarm control reads 0, the interrupt is low, and the debounce field reads 4.
- R2: Seconds do not advance until the key words at byte offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C have been written, in that order, with low bytes 0xC6, 0x9A, 0x59, 0xA3, 0x57, 0x67 and 0xD2.
- R3: Before the sequence completes, any key-word write with the wrong low byte or to the wrong position sends progress back to the first key. Once the sequence completes, the block stays unlocked until reset, and later key writes have no effect.
- R4: Bit 0 of the word at 0x20 is the stop bit. While it is 1, ticks are ignored and the alarm cannot fire. While it is 0 and the block is unlocked, each tick adds one second.
- R5: The live bank can be written only while the stop bit is 1. Writes to it while running are ignored. The alarm bank can be written at any time.
- R6: Seconds and minutes wrap after 59, hours after 23, weekday after 6, month after 12 back to 1, and year after 99 back to 0. Each wrap carries into the next field.
- R7: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, after 31 in the other months, and after 28 in month 2. In month 2 of a year divisible by 4 it wraps after 29 instead.
- R8: The alarm control word at 0x7C holds a master enable in bit 0 and compare enables in bits 1..7 for year, month, day, weekday, hour, minute and second. When a counting tick produces a time in which every enabled field equals the alarm bank, pending is set and alarm control reads 0.
- R9: The interrupt output equals pending AND an armed flag. Writing 0x7C loads the armed flag from bit 0. The hardware self-clear of alarm control leaves the armed flag unchanged.
- R10: Pending is bit 4 of the word at 0x30. Writing 1 to that bit clears it, and writing 0 has no effect. If a fire and a clear happen in the same cycle, the fire wins.
- R11: The word at 0x2C stores and returns only bits 2:0 as the debounce setting.
- R12: Field f (year=0 through second=6) of bank b is at 0x40 + 4*f + 0x20*b, with bank 0 live and bank 1 alarm. The two banks are independent. Key words and unused words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (8) | Byte address; bits 1:0 ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed word, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench uses the default parameters: a year span of 100, an 8-bit address and a 32-bit data word. A year span of 100 puts the 99-to-0 wrap and leap years at both 0 and 4 within a single directed load. Random start times are biased toward 23:57 and toward the last day of the month, so a few hundred ticks cross day, month and year boundaries often. The bench checks each of these crossings against its own calendar model.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int FLD_W      = 3;
    localparam int VAL_W      = 7;
    localparam int KEY_COUNT  = 7;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } cal_t;

    localparam int W_KEY_FIRST = 1;
    localparam int W_KEY_LAST  = 7;
    localparam int W_CTL       = 8;
    localparam int W_DEB       = 11;
    localparam int W_INT       = 12;
    localparam int W_BANK_LO   = 16;
    localparam int W_BANK_HI   = 30;
    localparam int W_ALCTL     = 31;
    localparam int PEND_BIT    = 4;

    function automatic cal_t cal_init();
        cal_t t;
        t     = '0;
        t.mon = 4'd1;
        t.dom = 5'd1;
        return t;
    endfunction

    function automatic logic [7:0] key_byte(logic [2:0] idx);
        case (idx)
            3'd0:    return 8'hC6;
            3'd1:    return 8'h9A;
            3'd2:    return 8'h59;
            3'd3:    return 8'hA3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            3'd6:    return 8'hD2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] fld_get(cal_t t, logic [FLD_W-1:0] f);
        case (f)
            3'd0:    return t.yr;
            3'd1:    return {3'b0, t.mon};
            3'd2:    return {2'b0, t.dom};
            3'd3:    return {4'b0, t.dow};
            3'd4:    return {2'b0, t.hr};
            3'd5:    return {1'b0, t.mn};
            3'd6:    return {1'b0, t.sc};
            default: return '0;
        endcase
    endfunction

    function automatic cal_t fld_set(cal_t t, logic [FLD_W-1:0] f, logic [VAL_W-1:0] v);
        cal_t r;
        r = t;
        case (f)
            3'd0:    r.yr  = v;
            3'd1:    r.mon = v[3:0];
            3'd2:    r.dom = v[4:0];
            3'd3:    r.dow = v[2:0];
            3'd4:    r.hr  = v[4:0];
            3'd5:    r.mn  = v[5:0];
            3'd6:    r.sc  = v[5:0];
            default: r     = t;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] month_len(logic [3:0] mon, logic leap);
        case (mon)
            4'd2:                   return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_unlock.sv
module cal_unlock
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr_i,
    input  logic [2:0] key_idx_i,
    input  logic [7:0] key_val_i,
    output logic       unlocked_o
);
    localparam int PW = $clog2(KEY_COUNT + 1);

    logic [PW-1:0] prog_d, prog_q;

    always_comb begin
        prog_d = prog_q;
        if (prog_q != PW'(KEY_COUNT) && key_wr_i) begin
            if (key_idx_i == 3'(prog_q) && key_val_i == key_byte(3'(prog_q)))
                prog_d = prog_q + PW'(1);
            else
                prog_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= '0;
        else        prog_q <= prog_d;
    end

    assign unlocked_o = (prog_q == PW'(KEY_COUNT));
endmodule

// File: rtl/cal_time.sv
module cal_time
    import cal_pkg::*;
#(
    parameter int YEAR_SPAN = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             wr_en_i,
    input  logic [FLD_W-1:0] wr_fld_i,
    input  logic [VAL_W-1:0] wr_val_i,
    output cal_t             cur_o,
    output cal_t             nxt_o
);
    localparam logic [6:0] YR_LAST = 7'(YEAR_SPAN - 1);

    cal_t cur_d, cur_q, step;
    logic leap;

    always_comb begin
        leap = (cur_q.yr[1:0] == 2'b00);
        step = cur_q;
        if (cur_q.sc >= 6'd59) begin
            step.sc = '0;
            if (cur_q.mn >= 6'd59) begin
                step.mn = '0;
                if (cur_q.hr >= 5'd23) begin
                    step.hr  = '0;
                    step.dow = (cur_q.dow >= 3'd6) ? 3'd0 : cur_q.dow + 3'd1;
                    if (cur_q.dom >= month_len(cur_q.mon, leap)) begin
                        step.dom = 5'd1;
                        if (cur_q.mon >= 4'd12) begin
                            step.mon = 4'd1;
                            step.yr  = (cur_q.yr >= YR_LAST) ? 7'd0 : cur_q.yr + 7'd1;
                        end else begin
                            step.mon = cur_q.mon + 4'd1;
                        end
                    end else begin
                        step.dom = cur_q.dom + 5'd1;
                    end
                end else begin
                    step.hr = cur_q.hr + 5'd1;
                end
            end else begin
                step.mn = cur_q.mn + 6'd1;
            end
        end else begin
            step.sc = cur_q.sc + 6'd1;
        end

        cur_d = cur_q;
        if (adv_i)        cur_d = step;
        else if (wr_en_i) cur_d = fld_set(cur_q, wr_fld_i, wr_val_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= cal_init();
        else        cur_q <= cur_d;
    end

    assign cur_o = cur_q;
    assign nxt_o = step;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_pkg::*;
(
    input  cal_t                  alarm_i,
    input  cal_t                  now_i,
    input  logic [NUM_FIELDS-1:0] en_i,
    output logic                  hit_o
);
    logic [NUM_FIELDS-1:0] eq;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        assign eq[f] = !en_i[f] ||
                       (fld_get(alarm_i, FLD_W'(f)) == fld_get(now_i, FLD_W'(f)));
    end

    assign hit_o = &eq;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_pkg::*;
#(
    parameter int         YEAR_SPAN = 100,
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 32,
    parameter logic [2:0] DEB_INIT  = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic       stop;
        logic [2:0] deb;
        logic       pend;
        logic       armed;
        logic [7:0] al_ctl;
        cal_t       alarm;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic [WORD_W-1:0] word;
    logic is_key, is_fld, bank;
    logic [FLD_W-1:0] fld;
    logic unlocked, run_tick, hit, fire, live_wr;
    cal_t live, live_nxt;
    logic unused_bits;

    assign word   = bus_addr[ADDR_W-1:2];
    assign is_key = (word >= WORD_W'(W_KEY_FIRST)) && (word <= WORD_W'(W_KEY_LAST));
    assign is_fld = (word >= WORD_W'(W_BANK_LO)) && (word <= WORD_W'(W_BANK_HI)) &&
                    (word[2:0] != 3'd7);
    assign bank   = word[3];
    assign fld    = word[2:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:8]};

    assign run_tick = sec_tick && unlocked && !st_q.stop;
    assign live_wr  = bus_wr && is_fld && !bank && st_q.stop;
    assign fire     = run_tick && st_q.al_ctl[0] && hit;

    cal_unlock u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (bus_wr && is_key),
        .key_idx_i  (3'(word - WORD_W'(W_KEY_FIRST))),
        .key_val_i  (bus_wdata[7:0]),
        .unlocked_o (unlocked)
    );

    cal_time #(.YEAR_SPAN(YEAR_SPAN)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (run_tick),
        .wr_en_i  (live_wr),
        .wr_fld_i (fld),
        .wr_val_i (bus_wdata[VAL_W-1:0]),
        .cur_o    (live),
        .nxt_o    (live_nxt)
    );

    cal_alarm_match u_match (
        .alarm_i (st_q.alarm),
        .now_i   (live_nxt),
        .en_i    (st_q.al_ctl[7:1]),
        .hit_o   (hit)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (word == WORD_W'(W_CTL)) st_d.stop = bus_wdata[0];
            if (word == WORD_W'(W_DEB)) st_d.deb  = bus_wdata[2:0];
            if (word == WORD_W'(W_INT) && bus_wdata[PEND_BIT]) st_d.pend = 1'b0;
            if (word == WORD_W'(W_ALCTL)) begin
                st_d.al_ctl = bus_wdata[7:0];
                st_d.armed  = bus_wdata[0];
            end
            if (is_fld && bank)
                st_d.alarm = fld_set(st_q.alarm, fld, bus_wdata[VAL_W-1:0]);
        end
        if (fire) begin
            st_d.pend   = 1'b1;
            st_d.al_ctl = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stop   <= 1'b1;
            st_q.deb    <= DEB_INIT;
            st_q.pend   <= 1'b0;
            st_q.armed  <= 1'b0;
            st_q.al_ctl <= '0;
            st_q.alarm  <= cal_init();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (is_fld)
            bus_rdata = DATA_W'(fld_get(bank ? st_q.alarm : live, fld));
        else if (word == WORD_W'(W_CTL))
            bus_rdata = DATA_W'(st_q.stop);
        else if (word == WORD_W'(W_DEB))
            bus_rdata = DATA_W'(st_q.deb);
        else if (word == WORD_W'(W_INT))
            bus_rdata = DATA_W'({st_q.pend, 4'b0});
        else if (word == WORD_W'(W_ALCTL))
            bus_rdata = DATA_W'(st_q.al_ctl);
    end

    assign irq_o = st_q.pend && st_q.armed;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       sec_tick,
    input logic       irq_o,
    input logic       pend,
    input logic       stop,
    input logic       unlocked,
    input logic [7:0] al_ctl,
    input cal_t       live
);
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend); // R9

    AST_FIRE_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (al_ctl == 8'd0)); // R8

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !bus_wr) |=> $stable(live)); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !bus_wr) |=> $stable(live)); // R4

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && unlocked && !stop && live.sc < 6'd59) |=>
        (live.sc == 6'($past(live.sc) + 6'd1))); // R4

    AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked); // R3
endmodule

bind cal_rtc cal_rtc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .sec_tick (sec_tick),
    .irq_o    (irq_o),
    .pend     (st_q.pend),
    .stop     (st_q.stop),
    .unlocked (unlocked),
    .al_ctl   (st_q.al_ctl),
    .live     (live)
);

// File: tb/sim_cal_rtc.sv
`timescale 1ns/1ps
module sim_cal_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    int m_y, m_mo, m_d, m_w, m_h, m_mi, m_s;

    always #10 clk = ~clk;

    cal_rtc u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_step();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_mi++;
        if (m_mi < 60) return;
        m_mi = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0; m_w = (m_w + 1) % 7; m_d++;
        if (m_d <= mdays(m_mo, m_y)) return;
        m_d = 1; m_mo++;
        if (m_mo <= 12) return;
        m_mo = 1; m_y = (m_y + 1) % 100;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        bus_addr = 8'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic chk_reg(string tag, int a, int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic chk_model(string tag);
        chk(tag, 0, 0);
        checks--;
        chk_reg({tag, " year"}, 8'h40, m_y);
        chk_reg({tag, " month"}, 8'h44, m_mo);
        chk_reg({tag, " day"}, 8'h48, m_d);
        chk_reg({tag, " wday"}, 8'h4C, m_w);
        chk_reg({tag, " hour"}, 8'h50, m_h);
        chk_reg({tag, " min"}, 8'h54, m_mi);
        chk_reg({tag, " sec"}, 8'h58, m_s);
    endtask

    task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
        wr(8'h20, 1);
        wr(8'h40, y); wr(8'h44, mo); wr(8'h48, d); wr(8'h4C, w);
        wr(8'h50, h); wr(8'h54, mi); wr(8'h58, s);
        wr(8'h20, 0);
        m_y = y; m_mo = mo; m_d = d; m_w = w; m_h = h; m_mi = mi; m_s = s;
    endtask

    task automatic keys(int first, int last);
        int kv[7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};
        for (int k = first; k <= last; k++) wr(4 + 4 * k, kv[k]);
    endtask

    task automatic roll(string tag, int y, int mo, int d, int w, int h, int mi, int s);
        set_time(y, mo, d, w, h, mi, s);
        tick();
        m_step();
        chk_model(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd20171));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        m_y = 0; m_mo = 1; m_d = 1; m_w = 0; m_h = 0; m_mi = 0; m_s = 0;
        chk_model("R1 live");
        chk_reg("R1 alarm month", 8'h64, 1);
        chk_reg("R1 alarm day", 8'h68, 1);
        chk_reg("R1 stop", 8'h20, 1);
        chk_reg("R1 pending", 8'h30, 0);
        chk_reg("R1 alctl", 8'h7C, 0);
        chk_reg("R1 debounce", 8'h2C, 4);
        chk("R1 irq", int'(irq_o), 0);

        // R2 locked: no counting even with stop cleared
        wr(8'h20, 0);
        tick(); tick();
        chk_reg("R2 locked sec", 8'h58, 0);

        // R3 wrong value mid-sequence restarts progress
        keys(0, 2);
        wr(8'h10, 8'h00);
        keys(3, 6);
        tick();
        chk_reg("R3 bad value relock", 8'h58, 0);
        // R3 out of order restarts progress
        keys(1, 1);
        keys(1, 6);
        tick();
        chk_reg("R3 out of order", 8'h58, 0);

        // R2 full sequence unlocks
        keys(0, 6);
        tick();
        chk_reg("R2 unlocked tick", 8'h58, 1);
        // R3 sticky after completion
        wr(8'h04, 8'h11);
        tick();
        chk_reg("R3 sticky unlock", 8'h58, 2);

        // R5 live write ignored while running
        wr(8'h58, 40);
        chk_reg("R5 run write ignored", 8'h58, 2);
        // R4 stop freezes
        wr(8'h20, 1);
        tick();
        chk_reg("R4 stopped tick", 8'h58, 2);
        wr(8'h58, 40);
        chk_reg("R5 stopped write", 8'h58, 40);
        wr(8'h20, 0);
        tick();
        chk_reg("R4 restart", 8'h58, 41);

        // R6 / R7 directed rollovers
        roll("R6 full wrap", 99, 12, 31, 6, 23, 59, 59);
        roll("R7 leap feb28", 4, 2, 28, 1, 23, 59, 59);
        roll("R7 leap feb29", 0, 2, 29, 2, 23, 59, 59);
        roll("R7 plain feb28", 5, 2, 28, 3, 23, 59, 59);
        roll("R7 apr30", 7, 4, 30, 4, 23, 59, 59);
        roll("R7 jan31", 7, 1, 31, 5, 23, 59, 59);
        roll("R7 jan30", 7, 1, 30, 5, 23, 59, 59);
        roll("R6 hour carry", 12, 6, 15, 0, 9, 59, 59);

        // R6 / R7 random runs against the model
        for (int it = 0; it < 40; it++) begin
            int y, mo, d, h, mi, n;
            y  = $urandom % 100;
            mo = 1 + $urandom % 12;
            d  = ($urandom % 3 == 0) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
            h  = ($urandom % 2 == 0) ? 23 : $urandom % 24;
            mi = ($urandom % 2 == 0) ? 57 : $urandom % 60;
            set_time(y, mo, d, $urandom % 7, h, mi, $urandom % 60);
            n = 1 + $urandom % 200;
            for (int t = 0; t < n; t++) begin
                tick();
                m_step();
                if ($urandom % 4 == 0) @(negedge clk);
            end
            chk_model("R6 R7 random");
        end

        // R8 / R9 alarm on hour and second
        set_time(5, 3, 10, 2, 8, 0, 10);
        wr(8'h70, 8); wr(8'h78, 13);
        wr(8'h7C, 8'hA1);
        tick(); tick();
        chk_reg("R8 before match", 8'h30, 0);
        tick();
        chk_reg("R8 pending set", 8'h30, 16);
        chk_reg("R8 ctl self clear", 8'h7C, 0);
        chk("R9 irq raised", int'(irq_o), 1);
        wr(8'h30, 0);
        chk_reg("R10 write zero keeps", 8'h30, 16);
        wr(8'h30, 16);
        chk_reg("R10 w1c", 8'h30, 0);
        chk("R10 irq low", int'(irq_o), 0);

        // R8 mismatched hour blocks the alarm
        wr(8'h70, 9); wr(8'h78, 15);
        wr(8'h7C, 8'hA1);
        tick(); tick();
        chk_reg("R8 hour mismatch", 8'h30, 0);
        chk_reg("R8 ctl kept", 8'h7C, 8'hA1);
        wr(8'h70, 8); wr(8'h78, 16);
        tick();
        chk_reg("R8 hour match", 8'h30, 16);
        wr(8'h7C, 0);
        chk("R9 masked", int'(irq_o), 0);
        chk_reg("R9 pending kept", 8'h30, 16);
        wr(8'h30, 16);

        // R8 master only fires on next tick; R4 stop blocks firing
        wr(8'h7C, 1);
        wr(8'h20, 1);
        tick();
        chk_reg("R4 no fire stopped", 8'h30, 0);
        wr(8'h20, 0);
        tick();
        chk_reg("R8 master only", 8'h30, 16);
        chk("R9 irq master", int'(irq_o), 1);
        wr(8'h30, 16);

        // R11 debounce width
        wr(8'h2C, 32'hFFFF_FFF8);
        chk_reg("R11 clear", 8'h2C, 0);
        wr(8'h2C, 32'h0000_00F5);
        chk_reg("R11 low bits", 8'h2C, 5);

        // R12 bank independence and unused words
        wr(8'h20, 1);
        wr(8'h40, 33);
        wr(8'h60, 77);
        chk_reg("R12 alarm year", 8'h60, 77);
        chk_reg("R12 live year", 8'h40, 33);
        chk_reg("R12 unused word", 8'h5C, 0);
        chk_reg("R12 key reads zero", 8'h04, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule